// File: doc/BRIEF.md
# Dual-Load Compute Execution Stage

This block is the execute stage of a 16-bit fixed-point datapath. It runs one arithmetic step and two operand loads in the same clock. The step is either an ALU operation, which writes a 16-bit result register, or a multiply-accumulate operation, which writes a 40-bit accumulator. The two loads come from two memory read ports. Words from the data-side port fill the X operand bank. Words from the program-side port fill the Y operand bank. Each bank holds four 16-bit registers.

Every register feeds the arithmetic with the value it held when the cycle began. Results and loaded words are committed together at the closing edge. A register can therefore be both an operand and a load target in one instruction, with no hazard and no stall. An 8-bit status register records the outcome. Each operation changes only the flags it owns, and every other flag holds its value.

Top module: `mfx_exec`

## Requirements
- R1: After reset, all eight bank registers, the result register, the accumulator and the status register read zero.
- R2: When a register is both an operand and a load target in one valid instruction, the arithmetic uses its old value, and after the edge the register holds the loaded word.
- R3: A valid instruction with `dmem_we_i` high writes `dmem_data_i` into X register `dmem_dst_i`, and with `pmem_we_i` high writes `pmem_data_i` into Y register `pmem_dst_i`. Both loads may happen in the same cycle. Bank index 0 to 3 occupies bits [16*i+15:16*i] of the bank output.
- R4: ALU codes write the result register one edge after a valid instruction. The codes are 1 add X+Y, 2 subtract X-Y, 3 and, 4 or, 5 xor, 6 pass X, 7 negate X and 8 absolute value of X.
- R5: An ALU operation sets status bit 0 when its result is zero and status bit 1 to the result sign.
- R6: Status bit 2 flags signed overflow and status bit 3 flags carry-out. Add and subtract take the carry from the 17-bit sum X+Y or X+~Y+1. Negate takes it from ~X+1, and for negate and absolute value overflow means X=0x8000. Logic and pass operations clear both bits.
- R7: Status bit 4 changes only on absolute value, where it is set when X is negative. Absolute value of 0x8000 returns 0x8000.
- R8: MAC codes write the 40-bit accumulator. Code 0x10 loads X*Y, 0x11 adds X*Y, 0x12 subtracts X*Y and 0x13 clears it. X*Y is a signed 16x16 product, sign-extended to 40 bits.
- R9: A MAC operation sets status bit 6 when accumulator bits [39:31] are not all equal, and clears it otherwise. ALU operations leave bit 6 unchanged.
- R10: Code 0, unassigned codes and cycles with `valid_i` low leave the result register, the accumulator and the status register unchanged. Loads still take place for code 0 and for unassigned codes, but not when `valid_i` is low.
- R11: Status bits that an operation does not own keep their values. ALU operations keep the accumulator, and MAC operations keep the result register. Bits 7 and 5 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction valid |
| func_i | input | 5 | ALU/MAC function code |
| xsel_i | input | 2 | X operand select |
| ysel_i | input | 2 | Y operand select |
| dmem_we_i | input | 1 | Data-side load enable |
| dmem_dst_i | input | 2 | X destination index |
| dmem_data_i | input | 16 | Data-side memory word |
| pmem_we_i | input | 1 | Program-side load enable |
| pmem_dst_i | input | 2 | Y destination index |
| pmem_data_i | input | 16 | Program-side memory word |
| xbank_o | output | 64 | All four X registers, packed |
| ybank_o | output | 64 | All four Y registers, packed |
| ar_o | output | 16 | ALU result register |
| mr_o | output | 40 | MAC accumulator |
| astat_o | output | 8 | Arithmetic status register |

## Verification
The bench builds the block with its defaults: 16-bit data, 8 guard bits and four registers per bank. With these values, 0x8000 times 0x8000 reaches 0x40000000, and one more accumulate crosses bit 31. The 32-bit overflow flag can therefore be raised and cleared again within a few instructions. The 16-bit width also puts the add, subtract, negate and absolute-value overflow corners at 0x7FFF and 0x8000, which the vector table uses directly.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

   typedef enum logic [4:0] {
      FN_NOP   = 5'h00,
      FN_ADD   = 5'h01,
      FN_SUB   = 5'h02,
      FN_AND   = 5'h03,
      FN_OR    = 5'h04,
      FN_XOR   = 5'h05,
      FN_PASSX = 5'h06,
      FN_NEG   = 5'h07,
      FN_ABS   = 5'h08,
      FN_MUL   = 5'h10,
      FN_MAC   = 5'h11,
      FN_MSUB  = 5'h12,
      FN_MCLR  = 5'h13
   } func_e;

   // status bit positions
   localparam int ST_AZ = 0;
   localparam int ST_AN = 1;
   localparam int ST_AV = 2;
   localparam int ST_AC = 3;
   localparam int ST_AS = 4;
   localparam int ST_MV = 6;
   localparam int ST_W  = 8;

   function automatic logic code_is_alu(input logic [4:0] f);
      return (f >= 5'h01) && (f <= 5'h08);
   endfunction

   function automatic logic code_is_mac(input logic [4:0] f);
      return (f >= 5'h10) && (f <= 5'h13);
   endfunction

endpackage

// File: rtl/mfx_bank.sv
module mfx_bank #(
   parameter  int DW   = 16,
   parameter  int NREG = 4,
   localparam int SW   = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SW-1:0]      wr_sel,
   input  logic [DW-1:0]      wr_data,
   input  logic [SW-1:0]      rd_sel,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] flat_o
);

   logic [DW-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && (wr_sel == SW'(g)))
            regs[g] <= wr_data;
      end
      assign flat_o[g*DW +: DW] = regs[g];
   end

   // start-of-cycle value: read path sees only the registered contents
   assign rd_data = regs[rd_sel];

endmodule

// File: rtl/mfx_alu.sv
module mfx_alu
   import mfx_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [4:0]    func,
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] y,
   output logic          op_ok,
   output logic [DW-1:0] res,
   output logic          f_av,
   output logic          f_ac,
   output logic          as_upd,
   output logic          f_as
);

   localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

   logic [DW:0] s_add, s_sub, s_neg;

   always_comb begin
      s_add  = {1'b0, x} + {1'b0, y};
      s_sub  = {1'b0, x} + {1'b0, ~y} + (DW+1)'(1);
      s_neg  = {1'b0, ~x} + (DW+1)'(1);
      op_ok  = 1'b1;
      res    = '0;
      f_av   = 1'b0;
      f_ac   = 1'b0;
      as_upd = 1'b0;
      f_as   = 1'b0;
      case (func)
         FN_ADD: begin
            res  = s_add[DW-1:0];
            f_ac = s_add[DW];
            f_av = (x[DW-1] == y[DW-1]) && (s_add[DW-1] != x[DW-1]);
         end
         FN_SUB: begin
            res  = s_sub[DW-1:0];
            f_ac = s_sub[DW];
            f_av = (x[DW-1] != y[DW-1]) && (s_sub[DW-1] != x[DW-1]);
         end
         FN_AND:   res = x & y;
         FN_OR:    res = x | y;
         FN_XOR:   res = x ^ y;
         FN_PASSX: res = x;
         FN_NEG: begin
            res  = s_neg[DW-1:0];
            f_ac = s_neg[DW];
            f_av = (x == MINV);
         end
         FN_ABS: begin
            res    = x[DW-1] ? s_neg[DW-1:0] : x;
            f_av   = (x == MINV);
            as_upd = 1'b1;
            f_as   = x[DW-1];
         end
         default: op_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/mfx_mac.sv
module mfx_mac
   import mfx_pkg::*;
#(
   parameter  int DW    = 16,
   parameter  int GUARD = 8,
   localparam int PW    = 2 * DW,
   localparam int MRW   = PW + GUARD
) (
   input  logic [4:0]     func,
   input  logic [DW-1:0]  x,
   input  logic [DW-1:0]  y,
   input  logic [MRW-1:0] mr_cur,
   output logic           op_ok,
   output logic [MRW-1:0] mr_nxt,
   output logic           f_mv
);

   logic signed [PW-1:0] prod;
   logic [MRW-1:0]       prod_x;

   always_comb begin
      prod   = $signed(x) * $signed(y);
      prod_x = {{GUARD{prod[PW-1]}}, prod};
      op_ok  = 1'b1;
      case (func)
         FN_MUL:  mr_nxt = prod_x;
         FN_MAC:  mr_nxt = mr_cur + prod_x;
         FN_MSUB: mr_nxt = mr_cur - prod_x;
         FN_MCLR: mr_nxt = '0;
         default: begin
            mr_nxt = mr_cur;
            op_ok  = 1'b0;
         end
      endcase
      // overflow out of the low product field: guard bits plus field sign disagree
      f_mv = !((&mr_nxt[MRW-1:PW-1]) || !(|mr_nxt[MRW-1:PW-1]));
   end

endmodule

// File: rtl/mfx_exec.sv
module mfx_exec
   import mfx_pkg::*;
#(
   parameter  int DW    = 16,
   parameter  int GUARD = 8,
   parameter  int NREG  = 4,
   localparam int SW    = $clog2(NREG),
   localparam int MRW   = 2 * DW + GUARD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [4:0]         func_i,
   input  logic [SW-1:0]      xsel_i,
   input  logic [SW-1:0]      ysel_i,
   input  logic               dmem_we_i,
   input  logic [SW-1:0]      dmem_dst_i,
   input  logic [DW-1:0]      dmem_data_i,
   input  logic               pmem_we_i,
   input  logic [SW-1:0]      pmem_dst_i,
   input  logic [DW-1:0]      pmem_data_i,
   output logic [NREG*DW-1:0] xbank_o,
   output logic [NREG*DW-1:0] ybank_o,
   output logic [DW-1:0]      ar_o,
   output logic [MRW-1:0]     mr_o,
   output logic [ST_W-1:0]    astat_o
);

   if (DW < 4) begin : g_bad_dw
      $error("mfx_exec: DW must be at least 4");
   end
   if (GUARD < 1) begin : g_bad_guard
      $error("mfx_exec: GUARD must be at least 1");
   end
   if ((NREG < 2) || ((1 << SW) != NREG)) begin : g_bad_nreg
      $error("mfx_exec: NREG must be a power of two, at least 2");
   end

   logic [DW-1:0]  x_op, y_op, alu_res;
   logic           alu_ok, alu_av, alu_ac, alu_as_upd, alu_as;
   logic           mac_ok, mac_mv;
   logic [MRW-1:0] mac_nxt;

   mfx_bank #(.DW(DW), .NREG(NREG)) u_xbank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(valid_i && dmem_we_i), .wr_sel(dmem_dst_i), .wr_data(dmem_data_i),
      .rd_sel(xsel_i), .rd_data(x_op), .flat_o(xbank_o)
   );

   mfx_bank #(.DW(DW), .NREG(NREG)) u_ybank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(valid_i && pmem_we_i), .wr_sel(pmem_dst_i), .wr_data(pmem_data_i),
      .rd_sel(ysel_i), .rd_data(y_op), .flat_o(ybank_o)
   );

   mfx_alu #(.DW(DW)) u_alu (
      .func(func_i), .x(x_op), .y(y_op),
      .op_ok(alu_ok), .res(alu_res), .f_av(alu_av), .f_ac(alu_ac),
      .as_upd(alu_as_upd), .f_as(alu_as)
   );

   mfx_mac #(.DW(DW), .GUARD(GUARD)) u_mac (
      .func(func_i), .x(x_op), .y(y_op), .mr_cur(mr_o),
      .op_ok(mac_ok), .mr_nxt(mac_nxt), .f_mv(mac_mv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ar_o    <= '0;
         mr_o    <= '0;
         astat_o <= '0;
      end else if (valid_i) begin
         if (alu_ok) begin
            ar_o           <= alu_res;
            astat_o[ST_AZ] <= (alu_res == '0);
            astat_o[ST_AN] <= alu_res[DW-1];
            astat_o[ST_AV] <= alu_av;
            astat_o[ST_AC] <= alu_ac;
            if (alu_as_upd)
               astat_o[ST_AS] <= alu_as;
         end
         if (mac_ok) begin
            mr_o           <= mac_nxt;
            astat_o[ST_MV] <= mac_mv;
         end
      end
   end

endmodule

// File: rtl/mfx_exec_chk.sv
module mfx_exec_chk
   import mfx_pkg::*;
#(
   parameter  int DW    = 16,
   parameter  int GUARD = 8,
   parameter  int NREG  = 4,
   localparam int SW    = $clog2(NREG),
   localparam int MRW   = 2 * DW + GUARD
) (
   input logic               clk,
   input logic               rst_n,
   input logic               valid_i,
   input logic [4:0]         func_i,
   input logic               dmem_we_i,
   input logic [SW-1:0]      dmem_dst_i,
   input logic [DW-1:0]      dmem_data_i,
   input logic               pmem_we_i,
   input logic [SW-1:0]      pmem_dst_i,
   input logic [DW-1:0]      pmem_data_i,
   input logic [NREG*DW-1:0] xbank_o,
   input logic [NREG*DW-1:0] ybank_o,
   input logic [DW-1:0]      ar_o,
   input logic [MRW-1:0]     mr_o,
   input logic [ST_W-1:0]    astat_o
);

   logic [DW-1:0] xr [NREG];
   logic [DW-1:0] yr [NREG];
   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign xr[g] = xbank_o[g*DW +: DW];
      assign yr[g] = ybank_o[g*DW +: DW];
   end

   logic is_alu, is_mac;
   assign is_alu = valid_i && code_is_alu(func_i);
   assign is_mac = valid_i && code_is_mac(func_i);

   AST_X_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && dmem_we_i) |=> (xr[$past(dmem_dst_i)] == $past(dmem_data_i))); // R3
   AST_Y_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && pmem_we_i) |=> (yr[$past(pmem_dst_i)] == $past(pmem_data_i))); // R3
   AST_X_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(xbank_o) && $stable(ybank_o)); // R10
   AST_NO_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_alu && !is_mac) |=> $stable(ar_o) && $stable(mr_o) && $stable(astat_o)); // R10
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      is_alu |=> (astat_o[ST_AZ] == (ar_o == '0))); // R5
   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      is_alu |=> (astat_o[ST_AN] == ar_o[DW-1])); // R5
   AST_ALU_KEEPS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
      is_alu |=> $stable(mr_o) && (astat_o[ST_MV] == $past(astat_o[ST_MV]))); // R9
   AST_MAC_KEEPS_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      is_mac |=> $stable(ar_o) && (astat_o[5:0] == $past(astat_o[5:0]))); // R11
   AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      is_mac |=> (astat_o[ST_MV] ==
                  !((&mr_o[MRW-1:2*DW-1]) || !(|mr_o[MRW-1:2*DW-1])))); // R9
   AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (astat_o[7] == 1'b0) && (astat_o[5] == 1'b0)); // R11

endmodule

bind mfx_exec mfx_exec_chk #(.DW(DW), .GUARD(GUARD), .NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i),
   .dmem_we_i(dmem_we_i), .dmem_dst_i(dmem_dst_i), .dmem_data_i(dmem_data_i),
   .pmem_we_i(pmem_we_i), .pmem_dst_i(pmem_dst_i), .pmem_data_i(pmem_data_i),
   .xbank_o(xbank_o), .ybank_o(ybank_o), .ar_o(ar_o), .mr_o(mr_o), .astat_o(astat_o)
);

// File: tb/test_mfx_exec.sv
module test_mfx_exec;
   import mfx_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [4:0]  func_i = '0;
   logic [1:0]  xsel_i = '0, ysel_i = '0, dmem_dst_i = '0, pmem_dst_i = '0;
   logic        dmem_we_i = 1'b0, pmem_we_i = 1'b0;
   logic [15:0] dmem_data_i = '0, pmem_data_i = '0;
   logic [63:0] xbank_o, ybank_o;
   logic [15:0] ar_o;
   logic [39:0] mr_o;
   logic [7:0]  astat_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   mfx_exec i_mfx_exec (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i),
      .xsel_i(xsel_i), .ysel_i(ysel_i),
      .dmem_we_i(dmem_we_i), .dmem_dst_i(dmem_dst_i), .dmem_data_i(dmem_data_i),
      .pmem_we_i(pmem_we_i), .pmem_dst_i(pmem_dst_i), .pmem_data_i(pmem_data_i),
      .xbank_o(xbank_o), .ybank_o(ybank_o), .ar_o(ar_o), .mr_o(mr_o), .astat_o(astat_o)
   );

   typedef struct packed {
      logic        vld;
      logic [4:0]  fn;
      logic [1:0]  xs;
      logic [1:0]  ys;
      logic        dwe;
      logic [1:0]  dd;
      logic [15:0] dv;
      logic        pwe;
      logic [1:0]  pd;
      logic [15:0] pv;
      logic [15:0] ear;
      logic [39:0] emr;
      logic [7:0]  est;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{1'b1, FN_NOP,   2'd0, 2'd0, 1'b1, 2'd0, 16'h0003, 1'b1, 2'd0, 16'h0005, 16'h0000, 40'h0,          8'h00},
      '{1'b1, FN_ADD,   2'd0, 2'd0, 1'b1, 2'd0, 16'h7FFF, 1'b1, 2'd0, 16'h0001, 16'h0008, 40'h0,          8'h00},
      '{1'b1, FN_ADD,   2'd0, 2'd0, 1'b1, 2'd1, 16'hFFFF, 1'b1, 2'd1, 16'h0001, 16'h8000, 40'h0,          8'h06},
      '{1'b1, FN_ADD,   2'd1, 2'd1, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h0000, 40'h0,          8'h09},
      '{1'b1, FN_SUB,   2'd0, 2'd1, 1'b1, 2'd2, 16'h8000, 1'b1, 2'd2, 16'h8000, 16'h7FFE, 40'h0,          8'h08},
      '{1'b1, FN_ABS,   2'd2, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h8000, 40'h0,          8'h16},
      '{1'b1, FN_MUL,   2'd2, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h8000, 40'h0040000000, 8'h16},
      '{1'b1, FN_MAC,   2'd2, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h8000, 40'h0080000000, 8'h56},
      '{1'b1, FN_AND,   2'd0, 2'd0, 1'b1, 2'd3, 16'h0002, 1'b1, 2'd3, 16'hFFFD, 16'h0001, 40'h0080000000, 8'h50},
      '{1'b1, FN_MSUB,  2'd3, 2'd3, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h0001, 40'h0080000006, 8'h50},
      '{1'b1, FN_MCLR,  2'd0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h0001, 40'h0,          8'h10},
      '{1'b1, FN_XOR,   2'd1, 2'd1, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'hFFFE, 40'h0,          8'h12},
      '{1'b1, 5'h1F,    2'd0, 2'd0, 1'b1, 2'd0, 16'h1234, 1'b0, 2'd0, 16'h0000, 16'hFFFE, 40'h0,          8'h12},
      '{1'b1, FN_PASSX, 2'd0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h1234, 40'h0,          8'h10},
      '{1'b0, FN_ADD,   2'd0, 2'd0, 1'b1, 2'd0, 16'h5555, 1'b1, 2'd0, 16'h5555, 16'h1234, 40'h0,          8'h10},
      '{1'b1, FN_PASSX, 2'd0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h1234, 40'h0,          8'h10},
      '{1'b1, FN_OR,    2'd2, 2'd3, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'hFFFD, 40'h0,          8'h12},
      '{1'b1, FN_NEG,   2'd2, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 16'h8000, 40'h0,          8'h16}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      valid_i   = 1'b0;
      dmem_we_i = 1'b0;
      pmem_we_i = 1'b0;
      func_i    = FN_NOP;
   endtask

   task automatic check_cleared(input string tag);
      check({tag, " xbank"}, 64'(xbank_o), 64'h0);
      check({tag, " ybank"}, 64'(ybank_o), 64'h0);
      check({tag, " ar"},    64'(ar_o),    64'h0);
      check({tag, " mr"},    64'(mr_o),    64'h0);
      check({tag, " astat"}, 64'(astat_o), 64'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_cleared("R1 reset");

      // vector walk: drive at a falling edge, the rising edge commits, sample at the next falling edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         valid_i     = TBL[i].vld;
         func_i      = TBL[i].fn;
         xsel_i      = TBL[i].xs;
         ysel_i      = TBL[i].ys;
         dmem_we_i   = TBL[i].dwe;
         dmem_dst_i  = TBL[i].dd;
         dmem_data_i = TBL[i].dv;
         pmem_we_i   = TBL[i].pwe;
         pmem_dst_i  = TBL[i].pd;
         pmem_data_i = TBL[i].pv;
         @(negedge clk);
         check($sformatf("R4 R2 R10 ar vec%0d", i),        64'(ar_o),    64'(TBL[i].ear));
         check($sformatf("R8 R10 mr vec%0d", i),           64'(mr_o),    64'(TBL[i].emr));
         check($sformatf("R5 R6 R7 R9 R11 st vec%0d", i),  64'(astat_o), 64'(TBL[i].est));
         idle_inputs();
      end

      // banks after the walk; the valid-low load of 0x5555 must not be present
      check("R3 R10 xbank final", 64'(xbank_o), 64'h0002_8000_FFFF_1234);
      check("R3 R10 ybank final", 64'(ybank_o), 64'hFFFD_8000_0001_0001);

      // same register used as operand and as load target: old value computes, new value lands
      @(negedge clk);
      valid_i = 1'b1; func_i = FN_PASSX; xsel_i = 2'd3;
      dmem_we_i = 1'b1; dmem_dst_i = 2'd3; dmem_data_i = 16'hABCD;
      @(negedge clk);
      check("R2 operand old value", 64'(ar_o), 64'h0002);
      check("R2 register new value", 64'(xbank_o[63:48]), 64'hABCD);
      idle_inputs();

      // reset again from a busy state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_cleared("R1 re-reset");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule